// File: doc/BRIEF.md
# Table-Driven Sequence Counter

This block is a small clocked counter whose successor state is not computed by arithmetic. The current state drives the read address of an eight-entry writable table held inside the block. On each enabled clock edge the state register takes the 3-bit word stored at that address. Any counting order, including orders that skip values, repeat a cycle or park in a single state, is produced by the table contents alone.

A host reprograms the order through a one-entry-per-cycle write port. A synchronous reset places the counter at a start value taken from an input, and it leaves the table untouched. A write that hits the entry being read in the same cycle takes effect only from the following cycle, so the step in progress always uses the entry as it stood before the edge.

Top module: `seq_table_counter`

## Requirements
- R1: The counter output is the state register itself, and that value is the read address of the next-state table.
- R2: On a rising clock edge with reset low and `step_en` high, the state becomes the table word stored at the present-state address.
- R3: On a rising clock edge with reset low and `step_en` low, the state keeps its value.
- R4: On a rising clock edge with `rst` high, the state loads `start_val`, and this takes priority over `step_en`.
- R5: Table contents are not cleared or altered by reset, and writes presented while reset is high are still stored.
- R6: A write with `tbl_we` high stores `tbl_wdata` at entry `tbl_waddr` on the clock edge and changes the state only if a later enabled edge reads that entry.
- R7: When a write targets the present-state entry on the same edge as an enabled step, the step uses the old word and the new word applies from the next edge.
- R8: An entry whose word equals its own address keeps the counter in that state on every enabled edge.
- R9: With entry 1 holding 5, entry 5 holding 4 and entry 4 holding 1, a counter started at 1 repeats the order 5, 4, 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; loads the start value |
| step_en | input | 1 | Advance the state from the table when high |
| start_val | input | 3 | State loaded on reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | 3 | Table entry to write |
| tbl_wdata | input | 3 | Word to store in the addressed entry |
| state_out | output | 3 | Present state |

## Verification
The bound checker watches every cycle that an enabled step lands on the word read before the edge, that a disabled step holds the state, that reset loads the start value ahead of the enable, that a colliding write does not leak into the current step, and that a self-pointing entry parks the counter. Whether a write actually landed in the right entry, whether the table survives reset, and whether a full programmed order such as 1, 5, 4 repeats can only be shown by the bench's scenarios, which program the table, walk sequences through it and compare each state against values worked out by hand.

// File: rtl/seqc_pkg.sv
package seqc_pkg;

    // Default width of a state value and of a table word.
    localparam int unsigned SEQC_STATE_W = 3;

    // Number of table entries for a given state width.
    function automatic int unsigned seqc_depth(input int unsigned w);
        return 32'd1 << w;
    endfunction

endpackage

// File: rtl/seqc_table.sv
module seqc_table #(
    parameter int unsigned STATE_W = seqc_pkg::SEQC_STATE_W,
    localparam int unsigned DEPTH  = seqc_pkg::seqc_depth(STATE_W)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [STATE_W-1:0] waddr,
    input  logic [STATE_W-1:0] wdata,
    input  logic [STATE_W-1:0] raddr,
    output logic [STATE_W-1:0] rdata
);

    typedef logic [STATE_W-1:0] word_t;

    // Table storage: no reset, so contents persist through a counter reset.
    word_t mem_d [DEPTH];
    word_t mem_q [DEPTH];

    // One write decoder per entry.
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_comb begin
            mem_d[e] = mem_q[e];
            if (we && (waddr == word_t'(e))) begin
                mem_d[e] = wdata;
            end
        end

        always_ff @(posedge clk) begin
            mem_q[e] <= mem_d[e];
        end
    end

    // Asynchronous read of the registered contents: a write in this cycle
    // is not visible until after the edge.
    always_comb begin
        rdata = mem_q[raddr];
    end

endmodule

// File: rtl/seqc_state.sv
module seqc_state #(
    parameter int unsigned STATE_W = seqc_pkg::SEQC_STATE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_en,
    input  logic [STATE_W-1:0] start_val,
    input  logic [STATE_W-1:0] next_word,
    output logic [STATE_W-1:0] state
);

    typedef struct packed {
        logic [STATE_W-1:0] cur;
    } st_t;

    st_t st_d;
    st_t st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cur = start_val;
        end else if (step_en) begin
            st_d.cur = next_word;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign state = st_q.cur;

endmodule

// File: rtl/seq_table_counter.sv
module seq_table_counter #(
    parameter int unsigned STATE_W = seqc_pkg::SEQC_STATE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_en,
    input  logic [STATE_W-1:0] start_val,
    input  logic               tbl_we,
    input  logic [STATE_W-1:0] tbl_waddr,
    input  logic [STATE_W-1:0] tbl_wdata,
    output logic [STATE_W-1:0] state_out
);

    logic [STATE_W-1:0] cur_state;
    logic [STATE_W-1:0] nxt_word;

    // R1: the present state is the table's read address.
    seqc_table #(.STATE_W(STATE_W)) u_tab (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_waddr),
        .wdata (tbl_wdata),
        .raddr (cur_state),
        .rdata (nxt_word)
    );

    seqc_state #(.STATE_W(STATE_W)) u_st (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .start_val (start_val),
        .next_word (nxt_word),
        .state     (cur_state)
    );

    assign state_out = cur_state;

endmodule

// File: rtl/seqc_checker.sv
module seqc_checker #(
    parameter int unsigned STATE_W = seqc_pkg::SEQC_STATE_W
) (
    input logic               clk,
    input logic               rst,
    input logic               step_en,
    input logic [STATE_W-1:0] start_val,
    input logic               tbl_we,
    input logic [STATE_W-1:0] tbl_waddr,
    input logic [STATE_W-1:0] state_q,
    input logic [STATE_W-1:0] rd_word
);

    // R4: reset loads the start value, ahead of the enable.
    a_r4_reset_loads_start: assert property (@(posedge clk)
        rst |=> state_q == $past(start_val));

    // R2: an enabled step lands on the word read before the edge.
    a_r2_step_from_table: assert property (@(posedge clk) disable iff (rst)
        step_en |=> state_q == $past(rd_word));

    // R3: disabled step holds the state.
    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(state_q));

    // R7: a write colliding with the current entry does not affect this step.
    a_r7_old_word_on_collision: assert property (@(posedge clk) disable iff (rst)
        (step_en && tbl_we && tbl_waddr == state_q) |=> state_q == $past(rd_word));

    // R8: a self-pointing entry parks the counter.
    a_r8_self_loop_parks: assert property (@(posedge clk) disable iff (rst)
        (step_en && rd_word == state_q) |=> $stable(state_q));

endmodule

bind seq_table_counter seqc_checker #(.STATE_W(STATE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .step_en   (step_en),
    .start_val (start_val),
    .tbl_we    (tbl_we),
    .tbl_waddr (tbl_waddr),
    .state_q   (state_out),
    .rd_word   (nxt_word)
);

// File: tb/sim_seq_table_counter.sv
module sim_seq_table_counter;

    logic       clk = 1'b0;
    logic       rst;
    logic       step_en;
    logic [2:0] start_val;
    logic       tbl_we;
    logic [2:0] tbl_waddr;
    logic [2:0] tbl_wdata;
    logic [2:0] state_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    seq_table_counter u0 (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .start_val (start_val),
        .tbl_we    (tbl_we),
        .tbl_waddr (tbl_waddr),
        .tbl_wdata (tbl_wdata),
        .state_out (state_out)
    );

    // {rst, en, start[2:0], we, waddr[2:0], wdata[2:0], expected[2:0]}
    localparam int NV = 33;
    localparam logic [14:0] VEC [NV] = '{
        {1'b1,1'b0,3'd1,1'b1,3'd0,3'd1,3'd1},  // 0  R4 reset to 1, write e0=1
        {1'b1,1'b0,3'd1,1'b1,3'd1,3'd5,3'd1},  // 1  R5 writes during reset
        {1'b1,1'b0,3'd1,1'b1,3'd2,3'd3,3'd1},  // 2
        {1'b1,1'b0,3'd1,1'b1,3'd3,3'd4,3'd1},  // 3
        {1'b1,1'b0,3'd1,1'b1,3'd4,3'd1,3'd1},  // 4
        {1'b1,1'b0,3'd1,1'b1,3'd5,3'd4,3'd1},  // 5
        {1'b1,1'b0,3'd1,1'b1,3'd6,3'd7,3'd1},  // 6
        {1'b1,1'b0,3'd1,1'b1,3'd7,3'd0,3'd1},  // 7
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd5},  // 8  R9 1->5
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd4},  // 9  R9 5->4
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd1},  // 10 R9 4->1
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd5},  // 11 R9 repeats, R2
        {1'b0,1'b0,3'd0,1'b0,3'd0,3'd0,3'd5},  // 12 R3 hold
        {1'b0,1'b0,3'd0,1'b1,3'd5,3'd2,3'd5},  // 13 R6 write, no step
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd2},  // 14 R6 new word used
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd3},  // 15 R2
        {1'b0,1'b1,3'd0,1'b1,3'd3,3'd6,3'd4},  // 16 R7 old word on collision
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd1},  // 17 R2
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd5},  // 18
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd2},  // 19
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd3},  // 20
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd6},  // 21 R7 new word applies later
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd7},  // 22
        {1'b0,1'b1,3'd0,1'b1,3'd7,3'd7,3'd0},  // 23 R7 collision again
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd1},  // 24 R1 state reads e0
        {1'b0,1'b0,3'd0,1'b1,3'd1,3'd1,3'd1},  // 25 R6 make e1 self-loop
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd1},  // 26 R8 parks
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd1},  // 27 R8 parks
        {1'b1,1'b1,3'd6,1'b0,3'd0,3'd0,3'd6},  // 28 R4 reset beats enable
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd7},  // 29 R5 e6 survived reset
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd7},  // 30 R8 e7 self-loop
        {1'b1,1'b0,3'd3,1'b0,3'd0,3'd0,3'd3},  // 31 R4
        {1'b0,1'b1,3'd0,1'b0,3'd0,3'd0,3'd6}   // 32 R5 e3=6 kept over reset
    };

    localparam int REQ [NV] = '{4,5,5,5,5,5,5,5, 9,9,9,2, 3,6,6,2,7,2,2,2,2,7,2,7,
                                1,6,8,8,4,5,8,4,5};

    task automatic check(input logic [2:0] exp, input int req, input string what);
        n_chk++;
        if (state_out !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: state_out=%0d expected=%0d", req, what, state_out, exp);
        end
    endtask

    task automatic drive(input logic r, input logic e, input logic [2:0] s,
                         input logic w, input logic [2:0] wa, input logic [2:0] wd);
        rst = r; step_en = e; start_val = s;
        tbl_we = w; tbl_waddr = wa; tbl_wdata = wd;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        drive(1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][14], VEC[i][13], VEC[i][12:10], VEC[i][9], VEC[i][8:6], VEC[i][5:3]);
            @(posedge clk);
            #1;
            check(VEC[i][2:0], REQ[i], $sformatf("vector %0d", i));
        end

        // Directed: reset with idle enable holds start value over several cycles (R3, R4).
        @(negedge clk);
        drive(1'b1, 1'b0, 3'd2, 1'b0, 3'd0, 3'd0);
        @(posedge clk); #1;
        check(3'd2, 4, "reset to 2");
        @(negedge clk);
        drive(1'b0, 1'b0, 3'd5, 1'b0, 3'd0, 3'd0);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            check(3'd2, 3, "idle hold after reset");
        end
        // Directed: step from 2 reads e2=3 (R2), then overwrite e3 while idle (R6).
        @(negedge clk);
        drive(1'b0, 1'b1, 3'd0, 1'b0, 3'd0, 3'd0);
        @(posedge clk); #1;
        check(3'd3, 2, "step 2->3");
        @(negedge clk);
        drive(1'b0, 1'b0, 3'd0, 1'b1, 3'd3, 3'd0);
        @(posedge clk); #1;
        check(3'd3, 6, "write while idle");
        @(negedge clk);
        drive(1'b0, 1'b1, 3'd0, 1'b0, 3'd0, 3'd0);
        @(posedge clk); #1;
        check(3'd0, 6, "rewritten entry 3 used");

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            finish_run();
        end
    end

endmodule